// File: doc/BRIEF.md
# Hardware Trap Arbiter

This block gathers run-time exception events from the core and picks one at a time to hand to the instruction sequencer. Events fall into three priority classes. The reset class holds hardware reset, software reset and watchdog expiry. Class A holds the non-maskable interrupt, stack overflow and stack underflow. Class B holds five illegal-operation sources that share one vector. The block also takes software trap requests that carry a 7-bit trap number. Every hardware event leaves a sticky mark in its own bit of a flag register, which software reads and clears by writing zeros.

A granted trap appears as a single-cycle acknowledge. On that cycle the block presents the vector address, the trap number and the class. While a hardware trap service runs, the block holds its class on a small level stack. A later event preempts it only if its class is strictly higher. A return input pops the stack. An interrupt-block output stays high while any hardware trap level is in service, so that ordinary interrupts and peripheral transfers cannot break into it. Software traps run at the caller's priority and never touch the level stack.

Top module: `trap_arbiter`

## Requirements
- R1: After a cycle with rst_n low, the flag register reads zero, ack_o is low, svc_lvl_o is 0 and irq_block_o is low.
- R2: An event sets its own flag bit and that bit stays set until software clears it. The bit positions are: reset class at bits 0 to 2 (hardware reset, software reset, watchdog), class A at bits 3 to 5 (NMI, stack overflow, stack underflow), class B at bits 6 to 10.
- R3: When flag_wr_i is high, every flag bit written as 0 is cleared. An event arriving in the same cycle as the write leaves its bit set.
- R4: A reset-class grant presents class 3, trap number 0x00 and vector 0x000000. It consumes every pending reset-class event.
- R5: A class A grant presents class 2. The trap number is 0x02 for NMI, 0x04 for stack overflow and 0x06 for stack underflow. When several class A events are pending together, NMI goes first, then stack overflow, then stack underflow, with one grant each.
- R6: A class B grant presents class 1, trap number 0x0A and vector 0x000028. One grant consumes every pending class B event.
- R7: A hardware event is granted only when its class is strictly above the level in service, so 3 beats 2 and 2 beats 1. An event that cannot be granted stays pending until the level in service drops below its class.
- R8: An event that is high in the cycle before clock edge E is recorded at E and can be acknowledged at edge E+1. The ack lasts one cycle. On every acknowledge the vector equals the trap number times 4.
- R9: Each hardware grant pushes its class, and svc_lvl_o shows the top of the stack, with 0 meaning none. A cycle with trap_ret_i high pops one level and grants nothing. irq_block_o is high exactly when svc_lvl_o is not 0.
- R10: A pending software trap is granted in any cycle that has no hardware grant and no return. It presents class 0, its own number, and the vector number times 4. It does not change svc_lvl_o.
- R11: Trap numbers 0x0B to 0x0F are never acknowledged, and a software request carrying one of them is discarded. A software request that arrives while another is still pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_evt_i | input | 3 | Reset-class events: hardware reset, software reset, watchdog |
| a_evt_i | input | 3 | Class A events: NMI, stack overflow, stack underflow |
| b_evt_i | input | 5 | Class B events |
| sw_req_i | input | 1 | Software trap request |
| sw_num_i | input | 7 | Software trap number |
| trap_ret_i | input | 1 | Return from trap service |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 11 | Flag write data; a 0 bit clears the flag |
| flag_rdata_o | output | 11 | Flag register contents |
| ack_o | output | 1 | Trap acknowledge pulse |
| ack_vec_o | output | VEC_W (24) | Vector address on acknowledge |
| ack_num_o | output | 8 | Trap number on acknowledge |
| ack_cls_o | output | 2 | Granted class: 3 reset, 2 A, 1 B, 0 software |
| svc_lvl_o | output | 2 | Class of the trap service in progress |
| irq_block_o | output | 1 | Block normal interrupts while a hardware trap is in service |

## Verification
On every cycle the assertions check the following:
- Each acknowledge pairs its class with the allowed trap numbers and carries a vector of four times the number.
- Reserved numbers never appear.
- Flags never drop without a write.
- Each hardware grant raises the interrupt block and comes from a class above the level in service before it.
- The block leaves the interrupt block only after a return, and a return cycle grants nothing.

Other behaviour needs the bench's scenarios, because it spans several cycles and depends on the stimulus:
- the fixed NMI, overflow, underflow order;
- events held pending behind a service and released after returns;
- an event winning over a clear in the same cycle;
- a software request ignored while another is pending;
- reserved numbers discarded.

// File: rtl/trap_pkg.sv
// Shared constants and types of the trap arbiter.
// Flag layout: reset class in the low bits, then class A, then class B.
package trap_pkg;
    localparam int N_RST  = 3;
    localparam int N_A    = 3;
    localparam int N_B    = 5;
    localparam int N_FLAG = N_RST + N_A + N_B;
    localparam int F_RST  = 0;
    localparam int F_A    = F_RST + N_RST;
    localparam int F_B    = F_A + N_A;
    localparam int SWN_W  = 7;
    localparam int NUM_W  = 8;
    localparam logic [NUM_W-1:0] NUM_RST = 8'h00;
    localparam logic [NUM_W-1:0] NUM_A0  = 8'h02;
    localparam logic [NUM_W-1:0] NUM_B   = 8'h0A;
    localparam logic [SWN_W-1:0] RSV_LO  = 7'h0B;
    localparam logic [SWN_W-1:0] RSV_HI  = 7'h0F;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_B    = 2'd1,
        LVL_A    = 2'd2,
        LVL_RST  = 2'd3
    } lvl_t;

    typedef struct packed {
        logic             vld;
        lvl_t             cls;
        logic [NUM_W-1:0] num;
    } grant_t;
endpackage

// File: rtl/trap_flag_reg.sv
// Sticky trap flag register.
// Assumes: set_i carries single-cycle event pulses; a write clears the
// bits written as 0, and a set in the same cycle wins over the clear.
module trap_flag_reg #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flags_q;

    // Per-bit update: clear by writing 0, OR in new events afterwards.
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else
                flags_q[i] <= (wr_i ? (flags_q[i] & wdata_i[i]) : flags_q[i]) | set_i[i];
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/trap_pick.sv
// Combinational trap selector.
// Picks the highest class whose pending events exceed the level in service.
// Within class A the lowest index wins. Software traps take the slot
// only if no hardware trap is chosen. hold_i (return cycle) suppresses all.
module trap_pick
    import trap_pkg::*;
(
    input  logic [N_FLAG-1:0] pend_i,
    input  lvl_t              cur_lvl_i,
    input  logic              hold_i,
    input  logic              sw_vld_i,
    input  logic [SWN_W-1:0]  sw_num_i,
    output grant_t            grant_o,
    output logic [N_FLAG-1:0] clr_o,
    output logic              sw_take_o
);
    logic [N_RST-1:0] p_rst;
    logic [N_A-1:0]   p_a;
    logic [N_B-1:0]   p_b;
    int               a_sel;

    assign p_rst = pend_i[F_RST +: N_RST];
    assign p_a   = pend_i[F_A +: N_A];
    assign p_b   = pend_i[F_B +: N_B];

    // Lowest-index pending class A source.
    always_comb begin
        a_sel = 0;
        for (int k = N_A - 1; k >= 0; k--) begin
            if (p_a[k]) a_sel = k;
        end
    end

    // Class-ordered selection and the pending bits it consumes.
    always_comb begin
        grant_o   = '0;
        clr_o     = '0;
        sw_take_o = 1'b0;
        if (!hold_i) begin
            if ((|p_rst) && (cur_lvl_i < LVL_RST)) begin
                grant_o.vld = 1'b1;
                grant_o.cls = LVL_RST;
                grant_o.num = NUM_RST;
                clr_o[F_RST +: N_RST] = '1;
            end else if ((|p_a) && (cur_lvl_i < LVL_A)) begin
                grant_o.vld = 1'b1;
                grant_o.cls = LVL_A;
                grant_o.num = NUM_A0 + NUM_W'(2 * a_sel);
                clr_o[F_A + a_sel] = 1'b1;
            end else if ((|p_b) && (cur_lvl_i < LVL_B)) begin
                grant_o.vld = 1'b1;
                grant_o.cls = LVL_B;
                grant_o.num = NUM_B;
                clr_o[F_B +: N_B] = '1;
            end else if (sw_vld_i) begin
                grant_o.vld = 1'b1;
                grant_o.cls = LVL_NONE;
                grant_o.num = NUM_W'(sw_num_i);
                sw_take_o   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trap_lvl_stack.sv
// Stack of in-service trap classes.
// Assumes: push and pop never occur in the same cycle, and pushes are
// strictly increasing in class, so DEPTH = 3 never overflows.
module trap_lvl_stack
    import trap_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  lvl_t             push_lvl_i,
    input  logic             pop_i,
    output lvl_t             top_o,
    output logic [CNT_W-1:0] cnt_o
);
    lvl_t             lvl_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    // Entry storage: a push writes the slot at the current count.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[i] <= LVL_NONE;
            else if (push_i && (cnt_q == CNT_W'(i)))
                lvl_q[i] <= push_lvl_i;
        end
    end

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push_i && (cnt_q != CNT_W'(DEPTH)))
            cnt_q <= cnt_q + 1'b1;
        else if (pop_i && (cnt_q != '0))
            cnt_q <= cnt_q - 1'b1;
    end

    // Top-of-stack read; empty reads as no level.
    always_comb begin
        top_o = LVL_NONE;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i + 1)) top_o = lvl_q[i];
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/trap_arbiter.sv
// Hardware trap arbiter top.
// Records events as pending and as sticky flags, grants one trap per
// cycle through trap_pick, registers the acknowledge and tracks the
// in-service class on trap_lvl_stack.
// Assumes: event inputs are single-cycle pulses; trap_ret_i is only
// raised by the core at the end of a trap service.
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int VEC_W     = 24,
    parameter int STK_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_RST-1:0]  rst_evt_i,
    input  logic [N_A-1:0]    a_evt_i,
    input  logic [N_B-1:0]    b_evt_i,
    input  logic              sw_req_i,
    input  logic [SWN_W-1:0]  sw_num_i,
    input  logic              trap_ret_i,
    input  logic              flag_wr_i,
    input  logic [N_FLAG-1:0] flag_wdata_i,
    output logic [N_FLAG-1:0] flag_rdata_o,
    output logic              ack_o,
    output logic [VEC_W-1:0]  ack_vec_o,
    output logic [NUM_W-1:0]  ack_num_o,
    output logic [1:0]        ack_cls_o,
    output logic [1:0]        svc_lvl_o,
    output logic              irq_block_o
);
    localparam int CNT_W = $clog2(STK_DEPTH + 1);

    logic [N_FLAG-1:0] evt;
    logic [N_FLAG-1:0] pend_q;
    logic [N_FLAG-1:0] clr;
    logic              sw_vld_q;
    logic [SWN_W-1:0]  sw_num_q;
    logic              sw_take;
    logic              sw_rsvd;
    grant_t            grant;
    lvl_t              cur_lvl;
    logic [CNT_W-1:0]  stk_cnt;
    logic              push;
    logic              ack_q;
    logic [NUM_W-1:0]  num_q;
    logic [1:0]        cls_q;

    assign evt     = {b_evt_i, a_evt_i, rst_evt_i};
    assign sw_rsvd = (sw_num_i >= RSV_LO) && (sw_num_i <= RSV_HI);
    assign push    = grant.vld && (grant.cls != LVL_NONE);

    trap_flag_reg #(.W(N_FLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt),
        .wr_i    (flag_wr_i),
        .wdata_i (flag_wdata_i),
        .flags_o (flag_rdata_o)
    );

    trap_pick u_pick (
        .pend_i    (pend_q),
        .cur_lvl_i (cur_lvl),
        .hold_i    (trap_ret_i),
        .sw_vld_i  (sw_vld_q),
        .sw_num_i  (sw_num_q),
        .grant_o   (grant),
        .clr_o     (clr),
        .sw_take_o (sw_take)
    );

    trap_lvl_stack #(.DEPTH(STK_DEPTH)) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .push_lvl_i (grant.cls),
        .pop_i      (trap_ret_i),
        .top_o      (cur_lvl),
        .cnt_o      (stk_cnt)
    );

    // Pending events: granted bits drop, new events are OR-ed in.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr) | evt;
    end

    // Software trap slot: one entry, reserved numbers and overlaps dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_vld_q <= 1'b0;
            sw_num_q <= '0;
        end else if (sw_req_i && !sw_vld_q && !sw_rsvd) begin
            sw_vld_q <= 1'b1;
            sw_num_q <= sw_num_i;
        end else if (sw_take) begin
            sw_vld_q <= 1'b0;
        end
    end

    // Registered acknowledge; fields are zero when no trap is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            num_q <= '0;
            cls_q <= '0;
        end else begin
            ack_q <= grant.vld;
            num_q <= grant.vld ? grant.num : '0;
            cls_q <= grant.vld ? grant.cls : 2'd0;
        end
    end

    assign ack_o       = ack_q;
    assign ack_num_o   = num_q;
    assign ack_cls_o   = cls_q;
    assign ack_vec_o   = VEC_W'(num_q) << 2;
    assign svc_lvl_o   = cur_lvl;
    assign irq_block_o = (cur_lvl != LVL_NONE);
endmodule

// File: rtl/trap_arbiter_chk.sv
// Property checker for trap_arbiter, attached by bind.
// Observes the acknowledge, level, flag and return signals.
module trap_arbiter_chk #(
    parameter int VEC_W     = 24,
    parameter int STK_DEPTH = 3,
    localparam int CNT_W    = $clog2(STK_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic [VEC_W-1:0] vec,
    input logic [7:0]       num,
    input logic [1:0]       cls,
    input logic [1:0]       svc_lvl,
    input logic             irq_block,
    input logic             trap_ret,
    input logic             flag_wr,
    input logic [10:0]      flags,
    input logic [CNT_W-1:0] stk_cnt
);
    p_vec_num_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ((vec >> 2) == VEC_W'(num)) && (vec[1:0] == 2'b00));

    p_no_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !((num >= 8'h0B) && (num <= 8'h0F)));

    p_rst_num_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (cls == 2'd3)) |-> (num == 8'h00));

    p_a_num_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (cls == 2'd2)) |-> ((num == 8'h02) || (num == 8'h04) || (num == 8'h06)));

    p_b_num_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (cls == 2'd1)) |-> (num == 8'h0A));

    p_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (cls != 2'd0)) |-> (cls > $past(svc_lvl)));

    p_block_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (cls != 2'd0)) |-> irq_block);

    p_block_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_block) |-> $past(trap_ret));

    p_ret_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_ret |=> !ack);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_cnt <= CNT_W'(STK_DEPTH));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind trap_arbiter trap_arbiter_chk #(.VEC_W(VEC_W), .STK_DEPTH(STK_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack_o),
    .vec       (ack_vec_o),
    .num       (ack_num_o),
    .cls       (ack_cls_o),
    .svc_lvl   (svc_lvl_o),
    .irq_block (irq_block_o),
    .trap_ret  (trap_ret_i),
    .flag_wr   (flag_wr_i),
    .flags     (flag_rdata_o),
    .stk_cnt   (stk_cnt)
);

// File: tb/sim_trap_arbiter.sv
`timescale 1ns/1ps
// Bench for trap_arbiter: directed corner cases, then seeded random
// stimulus, all compared every cycle against a model written from the
// requirements.
module sim_trap_arbiter;
    import trap_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  rst_evt;
    logic [2:0]  a_evt;
    logic [4:0]  b_evt;
    logic        sw_req;
    logic [6:0]  sw_num;
    logic        trap_ret;
    logic        flag_wr;
    logic [10:0] flag_wdata;
    logic [10:0] flag_rdata;
    logic        ack;
    logic [23:0] ack_vec;
    logic [7:0]  ack_num;
    logic [1:0]  ack_cls;
    logic [1:0]  svc_lvl;
    logic        irq_block;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    string scen  = "init";

    // Model state.
    logic [10:0] m_flags, m_pend;
    logic [1:0]  m_stk [3];
    int          m_cnt;
    logic        m_swv;
    logic [6:0]  m_swn;
    logic        m_ack;
    logic [7:0]  m_num;
    logic [1:0]  m_cls;
    logic        m_wr;

    always #2 clk = ~clk;

    trap_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .rst_evt_i(rst_evt), .a_evt_i(a_evt),
        .b_evt_i(b_evt), .sw_req_i(sw_req), .sw_num_i(sw_num),
        .trap_ret_i(trap_ret), .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
        .flag_rdata_o(flag_rdata), .ack_o(ack), .ack_vec_o(ack_vec),
        .ack_num_o(ack_num), .ack_cls_o(ack_cls), .svc_lvl_o(svc_lvl),
        .irq_block_o(irq_block)
    );

    function automatic logic [1:0] m_top();
        return (m_cnt == 0) ? 2'd0 : m_stk[m_cnt - 1];
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s (%s): actual=%0h expected=%0h", tag, scen, act, exp);
        end
    endtask

    task automatic idle_in();
        rst_evt = '0; a_evt = '0; b_evt = '0; sw_req = 0; sw_num = '0;
        trap_ret = 0; flag_wr = 0; flag_wdata = '0;
    endtask

    // One clock edge of the model, using the inputs held before it.
    task automatic model_step();
        logic [1:0]  lvl;
        logic        took, old_swv, hit;
        logic [10:0] e;
        if (!rst_n) begin
            m_flags = '0; m_pend = '0; m_cnt = 0; m_swv = 0; m_swn = '0;
            m_ack = 0; m_num = '0; m_cls = '0; m_wr = 0;
            return;
        end
        lvl = m_top(); took = 0; old_swv = m_swv;
        m_ack = 0; m_num = '0; m_cls = '0;
        if (!trap_ret) begin
            if (m_pend[2:0] != 0 && lvl < 2'd3) begin
                m_ack = 1; m_cls = 3; m_num = 8'h00; m_pend[2:0] = '0;
            end else if (m_pend[5:3] != 0 && lvl < 2'd2) begin
                hit = 0;
                for (int k = 0; k < 3; k++) begin
                    if (!hit && m_pend[3 + k]) begin
                        hit = 1; m_num = 8'(2 + 2 * k); m_pend[3 + k] = 0;
                    end
                end
                m_ack = 1; m_cls = 2;
            end else if (m_pend[10:6] != 0 && lvl < 2'd1) begin
                m_ack = 1; m_cls = 1; m_num = 8'h0A; m_pend[10:6] = '0;
            end else if (m_swv) begin
                m_ack = 1; m_cls = 0; m_num = {1'b0, m_swn}; took = 1;
            end
        end
        if (m_ack && m_cls != 0) begin
            m_stk[m_cnt] = m_cls; m_cnt++;
        end else if (trap_ret && m_cnt > 0) begin
            m_cnt--;
        end
        if (took) m_swv = 0;
        if (sw_req && !old_swv && !(sw_num >= 7'h0B && sw_num <= 7'h0F)) begin
            m_swv = 1; m_swn = sw_num;
        end
        e = {b_evt, a_evt, rst_evt};
        m_pend = m_pend | e;
        m_wr = flag_wr;
        m_flags = (flag_wr ? (m_flags & flag_wdata) : m_flags) | e;
    endtask

    task automatic compare();
        string t;
        t = (m_cls == 3) ? "R4" : (m_cls == 2) ? "R5" : (m_cls == 1) ? "R6" : "R10";
        chk("R8 ack", int'(ack), int'(m_ack));
        if (m_ack) begin
            chk(t, int'(ack_vec), int'({m_num, 2'b00}));
            chk(t, int'(ack_num), int'(m_num));
            chk(t, int'(ack_cls), int'(m_cls));
        end
        chk(m_wr ? "R3 flags" : "R2 flags", int'(flag_rdata), int'(m_flags));
        chk("R9 level", int'(svc_lvl), int'(m_top()));
        chk("R9 block", int'(irq_block), int'(m_top() != 0));
    endtask

    // Apply the current inputs across one edge, then check and clear them.
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        idle_in();
    endtask

    // Return and idle until nothing is in service or pending.
    task automatic drain();
        for (int i = 0; i < 40; i++) begin
            if (m_cnt == 0 && m_pend == 0 && !m_swv) break;
            trap_ret = (i % 2 == 0);
            cyc();
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        idle_in();
        rst_n = 0;
        @(negedge clk);
        repeat (3) cyc();
        scen = "reset";
        chk("R1 flags", int'(flag_rdata), 0);
        chk("R1 ack", int'(ack), 0);
        chk("R1 level", int'(svc_lvl), 0);
        chk("R1 block", int'(irq_block), 0);
        rst_n = 1;
        cyc();

        scen = "class A order";
        a_evt = 3'b111; cyc();
        cyc();
        chk("R5 nmi first", int'(ack_num), 2);
        chk("R8 vector", int'(ack_vec), 8);
        cyc();
        chk("R8 one cycle", int'(ack), 0);
        trap_ret = 1; cyc();
        cyc();
        chk("R5 overflow second", int'(ack_num), 4);
        trap_ret = 1; cyc();
        cyc();
        chk("R5 underflow third", int'(ack_num), 6);
        drain();

        scen = "preempt";
        b_evt = 5'b00100; cyc();
        cyc();
        chk("R6 shared number", int'(ack_num), 10);
        chk("R6 shared vector", int'(ack_vec), 24'h28);
        a_evt = 3'b001; cyc();
        cyc();
        chk("R7 A preempts B", int'(ack_cls), 2);
        b_evt = 5'b10000; cyc();
        cyc();
        chk("R7 B held under A", int'(ack), 0);
        trap_ret = 1; cyc();
        cyc();
        chk("R7 B held under B", int'(ack), 0);
        trap_ret = 1; cyc();
        cyc();
        chk("R7 B released", int'(ack_cls), 1);
        drain();

        scen = "clear vs set";
        flag_wr = 1; flag_wdata = '0; a_evt = 3'b001; cyc();
        chk("R3 set beats clear", int'(flag_rdata), 11'h008);
        drain();

        scen = "software";
        sw_req = 1; sw_num = 7'h45; cyc();
        cyc();
        chk("R10 sw class", int'(ack_cls), 0);
        chk("R10 sw vector", int'(ack_vec), 24'h114);
        chk("R10 level kept", int'(svc_lvl), 0);
        drain();

        scen = "reserved";
        sw_req = 1; sw_num = 7'h0C; cyc();
        for (int i = 0; i < 3; i++) begin
            cyc();
            chk("R11 reserved dropped", int'(ack), 0);
        end
        a_evt = 3'b001; sw_req = 1; sw_num = 7'h20; cyc();
        sw_req = 1; sw_num = 7'h30; cyc();
        chk("R5 hw before sw", int'(ack_num), 2);
        cyc();
        chk("R11 second request ignored", int'(ack_num), 8'h20);
        drain();

        scen = "reset class";
        rst_evt = 3'b101; b_evt = 5'b00001; cyc();
        chk("R2 reset flag bits", int'(flag_rdata[2:0]), 5);
        cyc();
        chk("R4 reset number", int'(ack_num), 0);
        chk("R4 reset class", int'(ack_cls), 3);
        drain();

        scen = "random";
        for (int n = 0; n < 3000; n++) begin
            rst_evt    = (($urandom % 40) == 0) ? 3'($urandom) : 3'd0;
            a_evt      = (($urandom % 10) == 0) ? 3'($urandom) : 3'd0;
            b_evt      = (($urandom % 8) == 0) ? 5'($urandom) : 5'd0;
            sw_req     = (($urandom % 8) == 0);
            sw_num     = (($urandom % 4) == 0) ? 7'(11 + ($urandom % 5)) : 7'($urandom);
            trap_ret   = (($urandom % 5) == 0);
            flag_wr    = (($urandom % 8) == 0);
            flag_wdata = 11'($urandom);
            cyc();
        end
        drain();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule